// File: doc/BRIEF.md
# Pulse-Width Bus Frame Receiver

This block receives frames from a single-wire bus that carries bits as the lengths of alternating active and passive states. A noise filter in front of it cleans up the bus signal. The receiver times every state in clock cycles and sorts each duration into one of these symbols: a data bit, a start-of-frame marker, an end of data, an idle bus, or a timing fault. Once a start-of-frame has been seen, it builds bytes most-significant bit first and pushes them into an external receive FIFO through a simple write port.

The last byte of every frame is a CRC-8. The receiver checks it and does not store it. When a frame ends, whether normally or because of a fault, the receiver writes one completion code byte into the same FIFO. The code summarizes the frame's outcome. A one-cycle interrupt strobe goes with that write. The receiver takes in every frame on the bus, including frames this node sends itself. All window limits are parameters counted in clock cycles. The defaults suit a 2 MHz clock.

Top module: `pulse_frame_rx`

## Requirements
- R1: Each state is classified by its duration in cycles. A passive state in [SHORT_MIN_CYC, LONG_MIN_CYC) is a 0 and one in [LONG_MIN_CYC, SOF_MIN_CYC) is a 1. An active state in [SHORT_MIN_CYC, LONG_MIN_CYC) is a 1 and one in [LONG_MIN_CYC, SOF_MIN_CYC) is a 0. Bits form bytes MSB first, and data bytes are written to the FIFO in arrival order.
- R2: While the receiver is idle, a frame starts only on an active state whose length is in [SOF_MIN_CYC, SOF_MAX_CYC). Any other active pulse while idle causes no FIFO write and no strobe.
- R3: The bus counts as idle after IDLE_CYC consecutive passive cycles. After a frame has ended, a start-of-frame is ignored until idle has been seen again.
- R4: Inside a frame, a passive state that reaches EOD_CYC cycles ends the frame. The most recent complete byte (the CRC) is never written to the FIFO.
- R5: The CRC is CRC-8 with polynomial 0x1D and initial value 0xFF, computed over every received bit including the CRC byte. A final register value other than 0xC4 sets completion bit 2.
- R6: Every frame end produces exactly one completion code write. Its bits are: bit 0 timing fault, bit 1 incomplete byte, bit 2 CRC error, bit 3 overrun, bit 4 lost arbitration. Bits 7:5 are zero, and a clean frame gives 0x00.
- R7: Inside a frame, an active or passive state outside every bit window, or an active state of start-of-frame length or longer, ends the frame at once with bit 0 set. Bit 1 is set if a byte is partly received. Data bytes already written stay in the FIFO.
- R8: A frame that ends on end-of-data with a bit count that is not a multiple of 8 sets bit 1.
- R9: A data write that would find fifo_full high is dropped and sets bit 3. No later data byte of that frame is written. fifo_wr_en is never asserted when fifo_full was high in the preceding cycle.
- R10: rx_irq pulses for exactly one cycle at each frame end. It pulses in the same cycle as the completion code write, and it still pulses when that write is dropped because the FIFO is full.
- R11: Bit 4 (lost arbitration) always reads 0, because this block has no transmit path.
- R12: After reset there are no writes and no strobe. The receiver waits for an idle bus before it accepts any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Filtered bus level, 1 = active |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | Data byte or completion code |
| rx_irq | output | 1 | One-cycle pulse at frame completion |

## Verification
The bench goes after these corner cases:
- **Frames with no data byte.** A bare start-of-frame followed by end-of-data must report only a CRC error. A frame holding only a CRC byte must report a clean frame. A design with an off-by-one in its one-byte holdback would either store the CRC or lose the last data byte.
- **Faults in mid-frame.** These are glitches too short for any window, and a start-of-frame-length active state inside a frame. A receiver that resynchronised instead of aborting would emit garbage bytes or no completion code.
- **Start-of-frame before idle.** A receiver that does not wait for idle would accept a start-of-frame arriving between end-of-data and idle.
- **FIFO full during data.** Holding fifo_full high during data must give an overrun code.
- **FIFO full at frame end.** Holding fifo_full high through the frame end must drop the code but keep the strobe, which a design that tied the strobe to the write would lose.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_SOF  = 2'd2,
    SYM_BAD  = 2'd3
  } sym_e;

  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_IDLE  = 2'd1,
    RX_FRAME = 2'd2
  } rx_state_e;

  localparam logic [7:0] CRC_POLY    = 8'h1D;
  localparam logic [7:0] CRC_INIT    = 8'hFF;
  localparam logic [7:0] CRC_RESIDUE = 8'hC4;

  localparam int CC_TIMING = 0;
  localparam int CC_PART   = 1;
  localparam int CC_CRC    = 2;
  localparam int CC_OVR    = 3;
  localparam int CC_ARB    = 4;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

endpackage

// File: rtl/pfr_state_timer.sv
module pfr_state_timer #(
  parameter int EOD_CYC  = 326,
  parameter int IDLE_CYC = 478,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_in,
  output logic          ev,
  output logic          ev_lvl,
  output logic [CW-1:0] ev_dur,
  output logic          eod_hit,
  output logic          idle_hit
);
  localparam logic [CW-1:0] CNT_SAT = CW'(IDLE_CYC + 1);
  localparam logic [CW-1:0] EOD_C   = CW'(EOD_CYC);
  localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_CYC);

  logic          bus_q;
  logic          lvl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= 1'b0;
      lvl    <= 1'b0;
      cnt    <= '0;
      ev     <= 1'b0;
      ev_lvl <= 1'b0;
      ev_dur <= '0;
    end else begin
      bus_q <= bus_in;
      if (bus_q != lvl) begin
        ev     <= 1'b1;
        ev_lvl <= lvl;
        ev_dur <= cnt;
        lvl    <= bus_q;
        cnt    <= CW'(1);
      end else begin
        ev <= 1'b0;
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign eod_hit  = !lvl && (cnt == EOD_C);
  assign idle_hit = !lvl && (cnt == IDLE_C);

  // a reported state always lasted at least one cycle
  assert_dur_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    ev |-> (ev_dur != '0));

endmodule

// File: rtl/pfr_symbol_classify.sv
module pfr_symbol_classify
  import pfr_pkg::*;
#(
  parameter int SHORT_MIN_CYC = 68,
  parameter int LONG_MIN_CYC  = 192,
  parameter int SOF_MIN_CYC   = 326,
  parameter int SOF_MAX_CYC   = 478,
  parameter int CW            = 9
) (
  input  logic          lvl,
  input  logic [CW-1:0] dur,
  output sym_e          sym
);
  localparam logic [CW-1:0] S_MIN  = CW'(SHORT_MIN_CYC);
  localparam logic [CW-1:0] L_MIN  = CW'(LONG_MIN_CYC);
  localparam logic [CW-1:0] F_MIN  = CW'(SOF_MIN_CYC);
  localparam logic [CW-1:0] F_MAX  = CW'(SOF_MAX_CYC);

  always_comb begin
    sym = SYM_BAD;
    if (lvl) begin
      if (dur < S_MIN)      sym = SYM_BAD;
      else if (dur < L_MIN) sym = SYM_ONE;
      else if (dur < F_MIN) sym = SYM_ZERO;
      else if (dur < F_MAX) sym = SYM_SOF;
      else                  sym = SYM_BAD;
    end else begin
      if (dur < S_MIN)      sym = SYM_BAD;
      else if (dur < L_MIN) sym = SYM_ZERO;
      else if (dur < F_MIN) sym = SYM_ONE;
      else                  sym = SYM_BAD;
    end
  end

endmodule

// File: rtl/pfr_frame_assembler.sv
module pfr_frame_assembler
  import pfr_pkg::*;
#(
  parameter int SOF_MIN_CYC = 326,
  parameter int SOF_MAX_CYC = 478,
  parameter int CW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          ev_lvl,
  input  logic [CW-1:0] ev_dur,
  input  sym_e          sym,
  input  logic          eod_hit,
  input  logic          idle_hit,
  input  logic          fifo_full,
  output logic          fifo_wr_en,
  output logic [7:0]    fifo_wr_data,
  output logic          rx_irq
);
  rx_state_e  state;
  logic [7:0] sh;
  logic [7:0] pend;
  logic       have_pend;
  logic [2:0] bitcnt;
  logic [7:0] crc;
  logic       ovr;

  logic       bit_val;
  logic [7:0] new_byte;
  logic [7:0] code_eod;
  logic [7:0] code_err;

  always_comb begin
    bit_val  = (sym == SYM_ONE);
    new_byte = {sh[6:0], bit_val};
    code_eod = 8'h00;
    code_eod[CC_PART] = (bitcnt != 3'd0);
    code_eod[CC_CRC]  = (crc != CRC_RESIDUE);
    code_eod[CC_OVR]  = ovr;
    code_eod[CC_ARB]  = 1'b0;
    code_err = 8'h00;
    code_err[CC_TIMING] = 1'b1;
    code_err[CC_PART]   = (bitcnt != 3'd0);
    code_err[CC_OVR]    = ovr;
    code_err[CC_ARB]    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RX_WAIT;
      sh           <= '0;
      pend         <= '0;
      have_pend    <= 1'b0;
      bitcnt       <= '0;
      crc          <= CRC_INIT;
      ovr          <= 1'b0;
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      rx_irq       <= 1'b0;
    end else begin
      fifo_wr_en <= 1'b0;
      rx_irq     <= 1'b0;
      case (state)
        RX_WAIT: begin
          if (idle_hit) state <= RX_IDLE;
        end
        RX_IDLE: begin
          if (ev && ev_lvl && sym == SYM_SOF) begin
            state     <= RX_FRAME;
            crc       <= CRC_INIT;
            bitcnt    <= '0;
            have_pend <= 1'b0;
            ovr       <= 1'b0;
          end
        end
        RX_FRAME: begin
          if (eod_hit) begin
            if (!fifo_full) begin
              fifo_wr_en   <= 1'b1;
              fifo_wr_data <= code_eod;
            end
            rx_irq <= 1'b1;
            state  <= RX_WAIT;
          end else if (ev) begin
            if (sym == SYM_ZERO || sym == SYM_ONE) begin
              sh  <= new_byte;
              crc <= crc8_step(crc, bit_val);
              if (bitcnt == 3'd7) begin
                bitcnt    <= '0;
                pend      <= new_byte;
                have_pend <= 1'b1;
                if (have_pend) begin
                  if (!fifo_full && !ovr) begin
                    fifo_wr_en   <= 1'b1;
                    fifo_wr_data <= pend;
                  end else begin
                    ovr <= 1'b1;
                  end
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else begin
              if (!fifo_full) begin
                fifo_wr_en   <= 1'b1;
                fifo_wr_data <= code_err;
              end
              rx_irq <= 1'b1;
              state  <= RX_WAIT;
            end
          end
        end
        default: state <= RX_WAIT;
      endcase
    end
  end

  // never write into a FIFO that reported full the cycle before
  assert_no_write_full_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> !$past(fifo_full));

  // the completion strobe lasts a single cycle
  assert_irq_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // entry into a frame only from idle on a start-of-frame-length active state
  assert_frame_needs_sof_R2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_FRAME && $past(state) != RX_FRAME) |->
      ($past(state) == RX_IDLE && $past(ev) && $past(ev_lvl) &&
       $past(ev_dur) >= CW'(SOF_MIN_CYC) && $past(ev_dur) < CW'(SOF_MAX_CYC)));

  // a completion write carries a clear arbitration bit and zero top bits
  assert_code_fields_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && fifo_wr_en) |-> (fifo_wr_data[7:4] == 4'h0));

endmodule

// File: rtl/pulse_frame_rx.sv
module pulse_frame_rx
  import pfr_pkg::*;
#(
  parameter int SHORT_MIN_CYC = 68,
  parameter int LONG_MIN_CYC  = 192,
  parameter int SOF_MIN_CYC   = 326,
  parameter int SOF_MAX_CYC   = 478,
  parameter int EOD_CYC       = 326,
  parameter int IDLE_CYC      = 478
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_in,
  input  logic       fifo_full,
  output logic       fifo_wr_en,
  output logic [7:0] fifo_wr_data,
  output logic       rx_irq
);
  localparam int CW = $clog2(IDLE_CYC + 2);

  logic          ev;
  logic          ev_lvl;
  logic [CW-1:0] ev_dur;
  logic          eod_hit;
  logic          idle_hit;
  sym_e          sym;

  pfr_state_timer #(
    .EOD_CYC (EOD_CYC),
    .IDLE_CYC(IDLE_CYC),
    .CW      (CW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .bus_in  (bus_in),
    .ev      (ev),
    .ev_lvl  (ev_lvl),
    .ev_dur  (ev_dur),
    .eod_hit (eod_hit),
    .idle_hit(idle_hit)
  );

  pfr_symbol_classify #(
    .SHORT_MIN_CYC(SHORT_MIN_CYC),
    .LONG_MIN_CYC (LONG_MIN_CYC),
    .SOF_MIN_CYC  (SOF_MIN_CYC),
    .SOF_MAX_CYC  (SOF_MAX_CYC),
    .CW           (CW)
  ) u_classify (
    .lvl(ev_lvl),
    .dur(ev_dur),
    .sym(sym)
  );

  pfr_frame_assembler #(
    .SOF_MIN_CYC(SOF_MIN_CYC),
    .SOF_MAX_CYC(SOF_MAX_CYC),
    .CW         (CW)
  ) u_asm (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .ev_lvl      (ev_lvl),
    .ev_dur      (ev_dur),
    .sym         (sym),
    .eod_hit     (eod_hit),
    .idle_hit    (idle_hit),
    .fifo_full   (fifo_full),
    .fifo_wr_en  (fifo_wr_en),
    .fifo_wr_data(fifo_wr_data),
    .rx_irq      (rx_irq)
  );

  // end-of-data must be reachable before the idle count, or frames never close
  initial begin
    assert_eod_before_idle_R4: assert (EOD_CYC < IDLE_CYC && SOF_MIN_CYC <= EOD_CYC);
  end

endmodule

// File: tb/tb_pulse_frame_rx.sv
`timescale 1ns/1ps
module tb_pulse_frame_rx;
  localparam int S_MIN = 6, L_MIN = 16, F_MIN = 26, F_MAX = 38, EOD = 26, IDLE = 38;
  localparam int D_SHORT = 10, D_LONG = 20, D_SOF = 31, D_GAP = 60;

  logic clk = 1'b0, rst = 1'b1, bus_in = 1'b0, fifo_full = 1'b0;
  logic fifo_wr_en, rx_irq;
  logic [7:0] fifo_wr_data;

  always #2.5 clk = ~clk;

  pulse_frame_rx #(
    .SHORT_MIN_CYC(S_MIN), .LONG_MIN_CYC(L_MIN), .SOF_MIN_CYC(F_MIN),
    .SOF_MAX_CYC(F_MAX), .EOD_CYC(EOD), .IDLE_CYC(IDLE)
  ) dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .rx_irq(rx_irq)
  );

  int n_checks = 0, n_fail = 0;
  int irq_n = 0, irq_wr = 0;
  logic [7:0] cap_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] data_q[$];
  bit bits_q[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_wr_en) cap_q.push_back(fifo_wr_data);
      if (rx_irq) begin
        irq_n++;
        if (fifo_wr_en) irq_wr++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(logic lvl, int n);
    bus_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] crc_bytes();
    logic [7:0] c = 8'hFF;
    foreach (data_q[i])
      for (int k = 7; k >= 0; k--) begin
        logic fb = c[7] ^ data_q[i][k];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
    return ~c;
  endfunction

  function automatic logic [7:0] crc_bits();
    logic [7:0] c = 8'hFF;
    foreach (bits_q[i]) begin
      logic fb = c[7] ^ bits_q[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return c;
  endfunction

  // data_q plus optional CRC byte into bits_q, MSB first
  task automatic build(bit add_crc, bit corrupt);
    logic [7:0] c;
    bits_q.delete();
    c = crc_bytes() ^ (corrupt ? 8'h01 : 8'h00);
    foreach (data_q[i])
      for (int k = 7; k >= 0; k--) bits_q.push_back(data_q[i][k]);
    if (add_crc)
      for (int k = 7; k >= 0; k--) bits_q.push_back(c[k]);
  endtask

  task automatic send_bits(int first, int last);
    for (int i = first; i <= last; i++) begin
      if (i % 2 == 0) hold(1'b0, bits_q[i] ? D_LONG : D_SHORT);
      else            hold(1'b1, bits_q[i] ? D_SHORT : D_LONG);
    end
  endtask

  function automatic logic [7:0] byte_at(int n);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = bits_q[n*8+k];
    return b;
  endfunction

  // expected writes for a frame closed by end-of-data
  task automatic expect_eod(bit ovr);
    int nfull = bits_q.size() / 8;
    logic [7:0] code = 8'h00;
    exp_q.delete();
    if (!ovr)
      for (int k = 0; k < nfull - 1; k++) exp_q.push_back(byte_at(k));
    code[1] = (bits_q.size() % 8) != 0;
    code[2] = crc_bits() != 8'hC4;
    code[3] = ovr;
    exp_q.push_back(code);
  endtask

  task automatic finish(string req, int exp_irq, int exp_irq_wr);
    hold(1'b0, D_GAP);
    chk(cap_q.size() == exp_q.size(), req, "write count", cap_q.size(), exp_q.size());
    if (cap_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(cap_q[i] == exp_q[i], req, "written byte", cap_q[i], exp_q[i]);
    chk(irq_n == exp_irq, req, "irq pulses", irq_n, exp_irq);
    chk(irq_wr == exp_irq_wr, req, "irq with code write", irq_wr, exp_irq_wr);
    cap_q.delete(); exp_q.delete(); irq_n = 0; irq_wr = 0;
  endtask

  task automatic rand_data(int n);
    data_q.delete();
    for (int i = 0; i < n; i++) data_q.push_back(8'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: quiet after reset
    chk(fifo_wr_en == 1'b0, "R12", "wr_en after reset", fifo_wr_en, 0);
    chk(rx_irq == 1'b0, "R12", "irq after reset", rx_irq, 0);
    // R12: a frame before idle is ignored
    hold(1'b0, 4);
    rand_data(2); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    exp_q.delete();
    finish("R12", 0, 0);

    // R1 R5 R6: random clean frames, 0..5 data bytes
    for (int f = 0; f < 10; f++) begin
      rand_data($urandom % 6); build(1, 0);
      hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
      expect_eod(0);
      finish("R1 R6", 1, 1);
    end

    // R5: bad CRC
    rand_data(3); build(1, 1);
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    expect_eod(0);
    finish("R5", 1, 1);

    // R4 R5: empty frame, SOF then end-of-data
    bits_q.delete();
    hold(1'b1, D_SOF);
    expect_eod(0);
    finish("R4", 1, 1);

    // R8: four trailing bits
    rand_data(2); build(1, 0);
    for (int k = 0; k < 4; k++) bits_q.push_back(1'($urandom));
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    expect_eod(0);
    finish("R8", 1, 1);

    // R7: short glitch after 12 bits
    rand_data(3); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, 11);
    hold(1'b0, 3); hold(1'b1, D_SHORT);
    exp_q.delete(); exp_q.push_back(8'h03);
    finish("R7", 1, 1);

    // R7: short glitch after 20 bits, first byte kept
    rand_data(3); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, 19);
    hold(1'b0, 3); hold(1'b1, D_SHORT);
    exp_q.delete(); exp_q.push_back(byte_at(0)); exp_q.push_back(8'h03);
    finish("R7", 1, 1);

    // R7: start-of-frame-length active state inside a frame
    rand_data(3); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, 16);
    hold(1'b1, D_SOF);
    exp_q.delete(); exp_q.push_back(byte_at(0)); exp_q.push_back(8'h03);
    finish("R7", 1, 1);

    // R2: a non-SOF active pulse while idle is ignored
    hold(1'b1, D_LONG);
    exp_q.delete();
    finish("R2", 0, 0);

    // R3: SOF between end-of-data and idle is ignored
    rand_data(2); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    expect_eod(0);
    hold(1'b0, EOD + 4);
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    finish("R3", 1, 1);

    // R9: FIFO full during data
    rand_data(3); build(1, 0);
    fifo_full = 1'b1;
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    hold(1'b0, 5);
    fifo_full = 1'b0;
    expect_eod(1);
    finish("R9", 1, 1);

    // R10: FIFO full at frame end, code dropped but strobe kept
    rand_data(2); build(1, 0);
    fifo_full = 1'b1;
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    exp_q.delete();
    finish("R10", 1, 0);
    fifo_full = 1'b0;

    // R11: clean frame after everything, arbitration bit zero
    rand_data(1); build(1, 0);
    hold(1'b1, D_SOF); send_bits(0, bits_q.size() - 1);
    expect_eod(0);
    finish("R11", 1, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule